// File: doc/BRIEF.md
# Skipper Pixel Integration Control Sequencer

This block is a cycle-accurate timing generator for an external switched dual-slope integrator. It produces four switch controls: an inverting-slope enable, a non-inverting-slope enable, an integrator discharge line and a sample-hold strobe. For every pixel it runs N slope pairs back to back on the same integrator capacitor, so the charge measurements pile up, and it never discharges between pairs. Each pair is an inverting (pedestal) slope, a hold gap for charge transfer, a non-inverting (charge) slope and a dead-time hold.

After the final pair, the sequencer pulses the sample-hold strobe for one cycle and raises a pixel-done pulse in the same cycle. It then discharges the integrator for a programmable number of cycles and returns to idle. A start pulse in idle launches a pixel. The sample count and all four durations are captured at that moment, and a zero in any of them counts as one. While a pixel runs, the index of the current slope pair is visible on an output.

Top module: `pix_seq_top`

## Requirements
- R1: After synchronous reset, and whenever idle, all four switch controls and `pix_done` are 0 and `samp_idx` is 0.
- R2: `start` sampled high at a clock edge in idle makes `int_neg`=1 and `int_pos`=0 from that edge, for exactly `cfg_tint` cycles per slope pair.
- R3: Both slope enables are 0 for exactly `cfg_tgap` cycles between the inverting and non-inverting slope of a pair, and for exactly `cfg_tdead` cycles after each non-inverting slope.
- R4: The non-inverting slope has `int_pos`=1 and `int_neg`=0 for exactly `cfg_tint` cycles.
- R5: A pixel runs exactly `cfg_nsamp` slope pairs with `int_rst` low throughout, and `samp_idx` equals k (0-based) for every cycle of pair k.
- R6: One cycle after the last dead time, `sh_strobe` and `pix_done` are both 1 for exactly one cycle, with `samp_idx` still at N-1.
- R7: Right after the strobe cycle, `int_rst` is 1 for exactly `cfg_trst` cycles with every other control 0. The block then spends at least one idle cycle before a new pixel can begin.
- R8: The sample count and durations are captured on the accepted start. Changes on the configuration inputs during a pixel have no effect on that pixel.
- R9: A configuration value of 0 behaves exactly as the value 1.
- R10: `start` has no effect while a pixel is in progress, including during the discharge phase. A `start` held high begins the next pixel one idle cycle after discharge ends.
- R11: `int_neg` and `int_pos` are never 1 together, and a change between them always passes through at least one cycle with both at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one pixel when idle |
| cfg_nsamp | input | NS_W | Slope pairs per pixel (0 treated as 1) |
| cfg_tint | input | CNT_W | Cycles per slope |
| cfg_tgap | input | CNT_W | Hold cycles between the two slopes |
| cfg_tdead | input | CNT_W | Hold cycles after the non-inverting slope |
| cfg_trst | input | CNT_W | Discharge pulse width in cycles |
| int_neg | output | 1 | Inverting-slope switch enable |
| int_pos | output | 1 | Non-inverting-slope switch enable |
| int_rst | output | 1 | Integrator discharge |
| sh_strobe | output | 1 | Sample-hold capture strobe |
| pix_done | output | 1 | Pixel-finished pulse |
| samp_idx | output | NS_W | Index of the current slope pair |

## Verification
Two events share a cycle by design: the sample-hold strobe and the pixel-done pulse. The scoreboard expects both in the single cycle after the final dead time and rejects either one alone. The second coincidence is a start request arriving during the last discharge cycle. The bench provokes it by holding `start` high across a whole pixel. It then judges that the discharge runs its full width, that exactly one idle cycle follows, and that the next pixel then begins with freshly captured settings. Start pulses and configuration changes injected mid-pixel are judged by confirming that the expected cycle stream is left untouched.

// File: rtl/pix_seq_pkg.sv
`timescale 1ns/1ps
package pix_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_NEG,
    PH_GAP,
    PH_POS,
    PH_DEAD,
    PH_SH,
    PH_RST
  } phase_t;

  typedef struct packed {
    logic neg;
    logic pos;
    logic dis;
    logic sh;
  } drive_t;

  // slots in the timing configuration vector
  localparam int T_SLOPE = 0;
  localparam int T_GAP   = 1;
  localparam int T_DEAD  = 2;
  localparam int T_DIS   = 3;
  localparam int T_NUM   = 4;

  function automatic drive_t phase_drive(phase_t p);
    drive_t d;
    d = '0;
    case (p)
      PH_NEG:  d.neg = 1'b1;
      PH_POS:  d.pos = 1'b1;
      PH_SH:   d.sh  = 1'b1;
      PH_RST:  d.dis = 1'b1;
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pix_seq_cfg.sv
`timescale 1ns/1ps
module pix_seq_cfg #(
  parameter int CNT_W = 16,
  parameter int NS_W  = 8,
  parameter int NT    = pix_seq_pkg::T_NUM
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [NT-1:0][CNT_W-1:0]   t_raw,
  input  logic [NS_W-1:0]            n_raw,
  output logic [NT-1:0][CNT_W-1:0]   t_lat,
  output logic [NS_W-1:0]            n_lat
);

  localparam logic [CNT_W-1:0] T_ONE = CNT_W'(1);
  localparam logic [NS_W-1:0]  N_ONE = NS_W'(1);

  logic [NT-1:0][CNT_W-1:0] t_clamp;
  logic [NS_W-1:0]          n_clamp;

  for (genvar g = 0; g < NT; g++) begin : g_clamp
    assign t_clamp[g] = (t_raw[g] == '0) ? T_ONE : t_raw[g];
  end

  assign n_clamp = (n_raw == '0) ? N_ONE : n_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NT; i++) t_lat[i] <= T_ONE;
      n_lat <= N_ONE;
    end else if (load) begin
      t_lat <= t_clamp;
      n_lat <= n_clamp;
    end
  end

  AST_LATCH_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (n_lat != '0) && (t_lat[0] != '0)); // R9

endmodule

// File: rtl/pix_seq_timer.sv
`timescale 1ns/1ps
module pix_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + CNT_W'(1);
  end

  assign last = (cnt == limit - CNT_W'(1));

endmodule

// File: rtl/pix_seq_ctrl.sv
`timescale 1ns/1ps
module pix_seq_ctrl
  import pix_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NS_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [T_NUM-1:0][CNT_W-1:0]  t_lat,
  input  logic [NS_W-1:0]              n_lat,
  output logic                         load,
  output logic                         int_neg,
  output logic                         int_pos,
  output logic                         int_rst,
  output logic                         sh_strobe,
  output logic                         pix_done,
  output logic [NS_W-1:0]              samp_idx
);

  phase_t           st, nx;
  logic             last;
  logic             last_samp;
  logic [CNT_W-1:0] lim;
  drive_t           drv;

  assign load      = (st == PH_IDLE) && start;
  assign last_samp = (samp_idx == n_lat - NS_W'(1));

  always_comb begin
    case (st)
      PH_NEG, PH_POS: lim = t_lat[T_SLOPE];
      PH_GAP:         lim = t_lat[T_GAP];
      PH_DEAD:        lim = t_lat[T_DEAD];
      PH_RST:         lim = t_lat[T_DIS];
      default:        lim = CNT_W'(1);
    endcase
  end

  pix_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (nx != st),
    .limit (lim),
    .last  (last)
  );

  always_comb begin
    nx = st;
    case (st)
      PH_IDLE: if (start) nx = PH_NEG;
      PH_NEG:  if (last)  nx = PH_GAP;
      PH_GAP:  if (last)  nx = PH_POS;
      PH_POS:  if (last)  nx = PH_DEAD;
      PH_DEAD: if (last)  nx = last_samp ? PH_SH : PH_NEG;
      PH_SH:              nx = PH_RST;
      PH_RST:  if (last)  nx = PH_IDLE;
      default:            nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= PH_IDLE;
    else     st <= nx;
  end

  always_ff @(posedge clk) begin
    if (rst)                                     samp_idx <= '0;
    else if (st == PH_DEAD && last && !last_samp) samp_idx <= samp_idx + NS_W'(1);
    else if (st == PH_SH)                         samp_idx <= '0;
  end

  // outputs registered from the next phase so they align with st
  always_ff @(posedge clk) begin
    if (rst) begin
      drv      <= '0;
      pix_done <= 1'b0;
    end else begin
      drv      <= phase_drive(nx);
      pix_done <= (nx == PH_SH);
    end
  end

  assign int_neg   = drv.neg;
  assign int_pos   = drv.pos;
  assign int_rst   = drv.dis;
  assign sh_strobe = drv.sh;

  AST_SLOPES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(int_neg && int_pos)); // R11
  AST_BREAK_BEFORE_POS: assert property (@(posedge clk) disable iff (rst)
    $rose(int_pos) |-> !$past(int_neg)); // R11
  AST_BREAK_BEFORE_NEG: assert property (@(posedge clk) disable iff (rst)
    $rose(int_neg) |-> !$past(int_pos)); // R11
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sh_strobe |=> !sh_strobe); // R6
  AST_STROBE_THEN_DISCHARGE: assert property (@(posedge clk) disable iff (rst)
    sh_strobe |=> int_rst); // R7
  AST_DISCHARGE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(int_rst) |-> $past(sh_strobe)); // R7
  AST_DISCHARGE_QUIET: assert property (@(posedge clk) disable iff (rst)
    int_rst |-> !(int_neg || int_pos || sh_strobe)); // R7
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    samp_idx < n_lat); // R5
  AST_NO_DISCHARGE_MIDPIXEL: assert property (@(posedge clk) disable iff (rst)
    (int_neg || int_pos) |-> !int_rst); // R5

endmodule

// File: rtl/pix_seq_top.sv
`timescale 1ns/1ps
module pix_seq_top #(
  parameter int CNT_W = 16,
  parameter int NS_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NS_W-1:0]  cfg_nsamp,
  input  logic [CNT_W-1:0] cfg_tint,
  input  logic [CNT_W-1:0] cfg_tgap,
  input  logic [CNT_W-1:0] cfg_tdead,
  input  logic [CNT_W-1:0] cfg_trst,
  output logic             int_neg,
  output logic             int_pos,
  output logic             int_rst,
  output logic             sh_strobe,
  output logic             pix_done,
  output logic [NS_W-1:0]  samp_idx
);
  import pix_seq_pkg::*;

  logic [T_NUM-1:0][CNT_W-1:0] t_raw;
  logic [T_NUM-1:0][CNT_W-1:0] t_lat;
  logic [NS_W-1:0]             n_lat;
  logic                        load;

  always_comb begin
    t_raw          = '0;
    t_raw[T_SLOPE] = cfg_tint;
    t_raw[T_GAP]   = cfg_tgap;
    t_raw[T_DEAD]  = cfg_tdead;
    t_raw[T_DIS]   = cfg_trst;
  end

  pix_seq_cfg #(.CNT_W(CNT_W), .NS_W(NS_W)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .t_raw (t_raw),
    .n_raw (cfg_nsamp),
    .t_lat (t_lat),
    .n_lat (n_lat)
  );

  pix_seq_ctrl #(.CNT_W(CNT_W), .NS_W(NS_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .t_lat     (t_lat),
    .n_lat     (n_lat),
    .load      (load),
    .int_neg   (int_neg),
    .int_pos   (int_pos),
    .int_rst   (int_rst),
    .sh_strobe (sh_strobe),
    .pix_done  (pix_done),
    .samp_idx  (samp_idx)
  );

  AST_DONE_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    pix_done == sh_strobe); // R6

endmodule

// File: tb/tb_pix_seq_top.sv
`timescale 1ns/1ps
module tb_pix_seq_top;

  localparam int CNT_W = 16;
  localparam int NS_W  = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [NS_W-1:0]  cfg_nsamp = '0;
  logic [CNT_W-1:0] cfg_tint = '0, cfg_tgap = '0, cfg_tdead = '0, cfg_trst = '0;
  logic             int_neg, int_pos, int_rst, sh_strobe, pix_done;
  logic [NS_W-1:0]  samp_idx;

  always #4 clk = ~clk;

  pix_seq_top #(.CNT_W(CNT_W), .NS_W(NS_W)) dut (
    .clk(clk), .rst(rst), .start(start),
    .cfg_nsamp(cfg_nsamp), .cfg_tint(cfg_tint), .cfg_tgap(cfg_tgap),
    .cfg_tdead(cfg_tdead), .cfg_trst(cfg_trst),
    .int_neg(int_neg), .int_pos(int_pos), .int_rst(int_rst),
    .sh_strobe(sh_strobe), .pix_done(pix_done), .samp_idx(samp_idx)
  );

  typedef struct {
    logic  neg, pos, dis, sh, done;
    int    idx;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   mon_on = 1'b0;
  bit   ended = 1'b0;

  function automatic int clamp1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int pix_len(int n, int ti, int tau, int psi, int tr);
    return clamp1(n) * (2*clamp1(ti) + clamp1(tau) + clamp1(psi)) + 1 + clamp1(tr);
  endfunction

  task automatic push_n(int cnt, logic ng, logic ps, logic ds, logic s, logic d, int ix, string tg);
    exp_t e;
    e.neg = ng; e.pos = ps; e.dis = ds; e.sh = s; e.done = d; e.idx = ix; e.tag = tg;
    for (int i = 0; i < cnt; i++) q.push_back(e);
  endtask

  // expected cycle stream of one pixel, from the requirements
  task automatic push_pixel(int n0, int ti0, int tau0, int psi0, int tr0, string extra);
    int n, ti, tau, psi, tr;
    n = clamp1(n0); ti = clamp1(ti0); tau = clamp1(tau0); psi = clamp1(psi0); tr = clamp1(tr0);
    for (int k = 0; k < n; k++) begin
      push_n(ti,  1, 0, 0, 0, 0, k, {"R2/R5", extra});
      push_n(tau, 0, 0, 0, 0, 0, k, {"R3/R5", extra});
      push_n(ti,  0, 1, 0, 0, 0, k, {"R4/R5", extra});
      push_n(psi, 0, 0, 0, 0, 0, k, {"R3/R5", extra});
    end
    push_n(1,  0, 0, 0, 1, 1, n-1, {"R6", extra});
    push_n(tr, 0, 0, 1, 0, 0, 0,   {"R7", extra});
  endtask

  task automatic set_cfg(int n, int ti, int tau, int psi, int tr);
    cfg_nsamp = NS_W'(n); cfg_tint = CNT_W'(ti); cfg_tgap = CNT_W'(tau);
    cfg_tdead = CNT_W'(psi); cfg_trst = CNT_W'(tr);
  endtask

  // one pixel from idle; disturb injects mid-pixel config change and start pulse
  task automatic run_pixel(int n, int ti, int tau, int psi, int tr, bit disturb, string extra);
    int len, used;
    len = pix_len(n, ti, tau, psi, tr);
    @(negedge clk);
    set_cfg(n, ti, tau, psi, tr);
    start = 1'b1;
    push_pixel(n, ti, tau, psi, tr, extra);
    @(negedge clk);
    start = 1'b0;
    used = 1;
    if (disturb) begin
      set_cfg(n + 2, ti + 3, tau + 1, psi + 4, tr + 2);   // R8
      repeat (3) @(negedge clk);
      start = 1'b1;                                       // R10
      @(negedge clk);
      start = 1'b0;
      used += 4;
    end
    repeat (len + 1 - used) @(negedge clk);
  endtask

  // monitor: pop one expected item per cycle, idle when queue is empty
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (mon_on && !ended) begin
        if (q.size() > 0) e = q.pop_front();
        else begin
          e.neg = 0; e.pos = 0; e.dis = 0; e.sh = 0; e.done = 0; e.idx = 0; e.tag = "R1/R10 idle";
        end
        n_cmp++;
        if (int_neg !== e.neg || int_pos !== e.pos || int_rst !== e.dis ||
            sh_strobe !== e.sh || pix_done !== e.done || int'(samp_idx) != e.idx) begin
          n_bad++;
          $display("FAIL %s t=%0t neg/pos/rst/sh/done/idx actual=%b%b%b%b%b/%0d expected=%b%b%b%b%b/%0d",
                   e.tag, $time, int_neg, int_pos, int_rst, sh_strobe, pix_done, samp_idx,
                   e.neg, e.pos, e.dis, e.sh, e.done, e.idx);
        end
        n_cmp++;
        if (int_neg && int_pos) begin
          n_bad++;
          $display("FAIL R11 both slopes active actual=11 expected=not both");
        end
      end
    end
  end

  initial begin
    #1500000;
    if (!ended) begin
      ended = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    n_cmp++;
    if ({int_neg, int_pos, int_rst, sh_strobe, pix_done} !== 5'b0 || samp_idx !== '0) begin
      n_bad++;
      $display("FAIL R1 reset state actual=%b%b%b%b%b/%0d expected=00000/0",
               int_neg, int_pos, int_rst, sh_strobe, pix_done, samp_idx);
    end
    mon_on = 1'b1;

    run_pixel(2, 3, 2, 1, 2, 1'b0, "");            // R2 R3 R4 R5 R6 R7
    run_pixel(3, 2, 1, 2, 3, 1'b1, " R8/R10");     // mid-pixel disturbance
    run_pixel(0, 0, 0, 0, 0, 1'b0, " R9");         // zeros act as ones
    run_pixel(4, 1, 1, 1, 1, 1'b0, " R11");        // tightest spacing

    // R10: start held high across two pixels
    @(negedge clk);
    set_cfg(1, 4, 3, 1, 1);
    start = 1'b1;
    len = pix_len(1, 4, 3, 1, 1);
    push_pixel(1, 4, 3, 1, 1, " R10");
    push_n(1, 0, 0, 0, 0, 0, 0, "R7/R10 idle gap");
    push_pixel(1, 4, 3, 1, 1, " R10");
    repeat (2*len + 1) @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);

    run_pixel(5, 2, 3, 1, 4, 1'b0, "");            // R5 longer pile-up
    repeat (3) @(negedge clk);

    if (!ended) begin
      ended = 1'b1;
      if (q.size() != 0) begin
        n_bad++;
        $display("FAIL R5 leftover expected items actual=%0d expected=0", q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule